// File: doc/BRIEF.md
# ADC Conversion-Group Result Buffer with Shared Interrupt

This block collects the results produced for one conversion group of an analog-to-digital converter. Each result arrives with its channel number and is held in a circular buffer of `DEPTH` slots. Software (or a transfer engine) takes results from the buffer in arrival order. The buffer tracks its occupancy in three named states:
- `BUF_EMPTY`
- `BUF_PARTIAL`
- `BUF_FULL`

The transitions between them are:
- `BUF_EMPTY` to `BUF_PARTIAL` on a stored result, or to `BUF_FULL` when `DEPTH` is 1.
- `BUF_PARTIAL` to `BUF_FULL` when the last free slot is taken.
- `BUF_PARTIAL` to `BUF_EMPTY` when the last result is popped.
- `BUF_FULL` to `BUF_PARTIAL` on a pop, or to `BUF_EMPTY` when `DEPTH` is 1.
- Any state to `BUF_EMPTY` on a flush.

Three events can request attention, and all three share one interrupt line:
- The end of a conversion sequence.
- A programmed number of stored results has been reached.
- A result has arrived at a buffer that is already full.

Each event has a sticky flag and an enable bit. The handler reads the flag bits to find the cause. A mode bit chooses what happens on a full buffer: the new result is dropped, or the oldest result is replaced. Writing a non-zero channel selection restarts the group and discards what has been stored.

Top module: `adc_grp_buf`

## Requirements
- R1: After reset the buffer is empty (`fill`=0, `rd_valid`=0), all flags are 0 and `irq` is 0.
- R2: Stored results leave in arrival order. `rd_data` shows the oldest entry `{chan,result}` while `rd_valid` is 1. A `pop` removes it, and `fill` counts the stored entries.
- R3: With mode bit 0 clear, a result that arrives while the buffer is full (and no pop in the same cycle) is dropped. `fill` and the buffer contents are unchanged.
- R4: A result that arrives at a full buffer with no pop in the same cycle sets overrun flag bit 2, in either mode.
- R5: With mode bit 0 set (register address 3), a result arriving at a full buffer replaces the oldest entry. `fill` stays at `DEPTH`, and the head becomes the next-oldest entry.
- R6: A `seq_end` strobe sets flag bit 0.
- R7: Writing address 2 loads the threshold and its down-counter. Each stored result decrements a non-zero counter. The step that brings it to zero sets flag bit 1.
- R8: Flags set whatever the enable bits (address 0, bit i enables flag i). `irq` is 1 exactly when some flag and its enable are both 1.
- R9: Writing address 1 clears the flags whose data bits are 1. A flag set event in the same cycle wins over the clear.
- R10: Writing a non-zero value to address 4 empties the buffer and reloads the threshold counter. Writing zero there has no effect.
- R11: A `pop` while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_vld | input | 1 | Conversion result strobe |
| res_data | input | DATA_W | Conversion result |
| res_chan | input | CHAN_W | Channel of the result |
| seq_end | input | 1 | End-of-sequence strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 enable, 1 flag clear, 2 threshold, 3 mode, 4 channel select) |
| reg_wdata | input | REG_W | Register write data |
| pop | input | 1 | Remove the oldest entry |
| rd_data | output | CHAN_W+DATA_W | Oldest entry, channel in the upper bits |
| rd_valid | output | 1 | Buffer holds at least one entry |
| fill | output | $clog2(DEPTH+1) | Number of stored entries |
| irq | output | 1 | Group interrupt request |
| flags | output | 3 | Flags: bit 0 sequence end, bit 1 threshold, bit 2 overrun |

## Verification
The bench fills the buffer to exactly `DEPTH` and then offers one result more. It checks the drop mode and the overwrite mode separately:
- A design that wrapped its write pointer over unread data would change the head in drop mode.
- A design that forgot to advance the read pointer when overwriting would show a stale head.

The bench also writes a flag clear in the same cycle as an overrun. A design that let the clear win would lose the cause. Further checks cover three more faults:
- Writing zero to the channel select, which a careless decoder would treat as a flush.
- Stepping the threshold counter to exactly zero, where an off-by-one would raise the flag a result early or late.
- Raising a flag whose enable is clear, which must leave `irq` low.

// File: rtl/adc_grp_pkg.sv
package adc_grp_pkg;
    typedef enum logic [1:0] {BUF_EMPTY, BUF_PARTIAL, BUF_FULL} buf_st_e;

    localparam int NFLG    = 3;
    localparam int FLG_EOS = 0;
    localparam int FLG_THR = 1;
    localparam int FLG_OVR = 2;

    localparam logic [2:0] A_ENA   = 3'd0;
    localparam logic [2:0] A_FLAG  = 3'd1;
    localparam logic [2:0] A_THR   = 3'd2;
    localparam logic [2:0] A_MODE  = 3'd3;
    localparam logic [2:0] A_CHSEL = 3'd4;
endpackage

// File: rtl/adc_grp_fifo.sv
module adc_grp_fifo
    import adc_grp_pkg::*;
#(
    parameter int W     = 17,
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [W-1:0]                din,
    input  logic                        pop,
    input  logic                        flush,
    input  logic                        ovr_ign,
    output logic [W-1:0]                dout,
    output logic                        rd_valid,
    output logic [$clog2(DEPTH+1)-1:0]  fill,
    output logic                        stored,
    output logic                        overrun
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    buf_st_e          st, st_nxt;
    logic [W-1:0]     mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt;
    logic             full, room, do_pop, do_push, overwrite, grow, shrink;

    function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign do_pop    = pop && rd_valid && !flush;
    assign room      = !full || do_pop;
    assign do_push   = push && !flush && (room || ovr_ign);
    assign overwrite = push && !flush && !room && ovr_ign;
    assign grow      = do_push && !do_pop && !overwrite;
    assign shrink    = do_pop && !do_push;
    assign stored    = do_push;
    assign overrun   = push && !flush && !room;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= BUF_EMPTY;
        else        st <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            BUF_EMPTY:   if (grow) st_nxt = (DEPTH == 1) ? BUF_FULL : BUF_PARTIAL;
            BUF_PARTIAL: if (grow && cnt == CW'(DEPTH - 1)) st_nxt = BUF_FULL;
                         else if (shrink && cnt == CW'(1)) st_nxt = BUF_EMPTY;
            BUF_FULL:    if (shrink) st_nxt = (DEPTH == 1) ? BUF_EMPTY : BUF_PARTIAL;
            default:     st_nxt = BUF_EMPTY;
        endcase
        if (flush) st_nxt = BUF_EMPTY;
    end

    // outputs decoded from state
    always_comb begin
        unique case (st)
            BUF_EMPTY:   begin rd_valid = 1'b0; full = 1'b0; end
            BUF_PARTIAL: begin rd_valid = 1'b1; full = 1'b0; end
            BUF_FULL:    begin rd_valid = 1'b1; full = 1'b1; end
            default:     begin rd_valid = 1'b0; full = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push)             wr_ptr <= inc(wr_ptr);
            if (do_pop || overwrite) rd_ptr <= inc(rd_ptr);
            if (grow)                cnt <= cnt + CW'(1);
            else if (shrink)         cnt <= cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    assign dout = mem[rd_ptr];
    assign fill = cnt;

    a_r3_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush && !ovr_ign) |=> (full && $stable(rd_ptr) && fill == CW'(DEPTH)));
    a_r5_overwrite_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush && ovr_ign) |=> (full && fill == CW'(DEPTH)));
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!rd_valid && fill == '0));
    a_r11_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && pop && !push && !flush) |=> (!rd_valid && fill == '0));
endmodule

// File: rtl/adc_grp_irq.sv
module adc_grp_irq
    import adc_grp_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_eos,
    input  logic              ev_ovr,
    input  logic              stored,
    input  logic              clr_wr,
    input  logic [NFLG-1:0]   clr_mask,
    input  logic              thr_wr,
    input  logic [THR_W-1:0]  thr_val,
    input  logic              reload,
    input  logic [NFLG-1:0]   ena,
    output logic [NFLG-1:0]   flags,
    output logic              irq
);
    logic [THR_W-1:0] thr_reg, thr_cnt;
    logic             thr_hit;
    logic [NFLG-1:0]  set_v, clr_v;

    assign thr_hit = stored && !thr_wr && (thr_cnt == THR_W'(1));

    always_comb begin
        set_v          = '0;
        set_v[FLG_EOS] = ev_eos;
        set_v[FLG_THR] = thr_hit;
        set_v[FLG_OVR] = ev_ovr;
        clr_v          = clr_wr ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_reg <= '0;
            thr_cnt <= '0;
        end else if (thr_wr) begin
            thr_reg <= thr_val;
            thr_cnt <= thr_val;
        end else if (reload) begin
            thr_cnt <= thr_reg;
        end else if (stored && thr_cnt != '0) begin
            thr_cnt <= thr_cnt - THR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_v) | set_v;
    end

    assign irq = |(flags & ena);

    a_r6_eos_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_eos |=> flags[FLG_EOS]);
    a_r9_ovr_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ovr && clr_wr && clr_mask[FLG_OVR]) |=> flags[FLG_OVR]);
    a_r7_thr_zero_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (stored && !thr_wr && !reload && thr_cnt == THR_W'(1)) |=> (flags[FLG_THR] && thr_cnt == '0));
endmodule

// File: rtl/adc_grp_buf.sv
module adc_grp_buf
    import adc_grp_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 5,
    parameter int DEPTH  = 16,
    parameter int THR_W  = 8,
    parameter int REG_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        res_vld,
    input  logic [DATA_W-1:0]           res_data,
    input  logic [CHAN_W-1:0]           res_chan,
    input  logic                        seq_end,
    input  logic                        reg_wr,
    input  logic [2:0]                  reg_addr,
    input  logic [REG_W-1:0]            reg_wdata,
    input  logic                        pop,
    output logic [CHAN_W+DATA_W-1:0]    rd_data,
    output logic                        rd_valid,
    output logic [$clog2(DEPTH+1)-1:0]  fill,
    output logic                        irq,
    output logic [2:0]                  flags
);
    localparam int ENT_W = CHAN_W + DATA_W;

    logic [NFLG-1:0] ena_q;
    logic            ign_q;
    logic            wr_ena, wr_flag, wr_thr, wr_mode, flush;
    logic            stored, overrun;

    assign wr_ena  = reg_wr && reg_addr == A_ENA;
    assign wr_flag = reg_wr && reg_addr == A_FLAG;
    assign wr_thr  = reg_wr && reg_addr == A_THR;
    assign wr_mode = reg_wr && reg_addr == A_MODE;
    assign flush   = reg_wr && reg_addr == A_CHSEL && reg_wdata != '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= '0;
            ign_q <= 1'b0;
        end else begin
            if (wr_ena)  ena_q <= reg_wdata[NFLG-1:0];
            if (wr_mode) ign_q <= reg_wdata[0];
        end
    end

    adc_grp_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (res_vld),
        .din      ({res_chan, res_data}),
        .pop      (pop),
        .flush    (flush),
        .ovr_ign  (ign_q),
        .dout     (rd_data),
        .rd_valid (rd_valid),
        .fill     (fill),
        .stored   (stored),
        .overrun  (overrun)
    );

    adc_grp_irq #(.THR_W(THR_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_eos   (seq_end),
        .ev_ovr   (overrun),
        .stored   (stored),
        .clr_wr   (wr_flag),
        .clr_mask (reg_wdata[NFLG-1:0]),
        .thr_wr   (wr_thr),
        .thr_val  (reg_wdata[THR_W-1:0]),
        .reload   (flush),
        .ena      (ena_q),
        .flags    (flags),
        .irq      (irq)
    );

    a_r4_full_arrival_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && fill == $bits(fill)'(DEPTH) && !pop && !flush) |=> flags[FLG_OVR]);
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |-> !irq);
endmodule

// File: tb/sim_adc_grp_buf.sv
module sim_adc_grp_buf;
    localparam int DATA_W = 12;
    localparam int CHAN_W = 5;
    localparam int DEPTH  = 16;
    localparam int ENT_W  = CHAN_W + DATA_W;
    localparam int CW     = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              res_vld = 1'b0;
    logic [DATA_W-1:0] res_data = '0;
    logic [CHAN_W-1:0] res_chan = '0;
    logic              seq_end = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic              pop = 1'b0;
    logic [ENT_W-1:0]  rd_data;
    logic              rd_valid;
    logic [CW-1:0]     fill;
    logic              irq;
    logic [2:0]        flags;

    int errs = 0;
    int checks = 0;
    bit running = 0;
    bit done = 0;

    always #2 clk = ~clk;

    adc_grp_buf u0 (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_data(res_data),
        .res_chan(res_chan), .seq_end(seq_end), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pop(pop),
        .rd_data(rd_data), .rd_valid(rd_valid), .fill(fill), .irq(irq), .flags(flags)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [ENT_W-1:0] q[$];
    logic [2:0]       m_flags, m_ena;
    bit               m_ign;
    int               m_thr, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_flags = '0; m_ena = '0; m_ign = 0; m_thr = 0; m_cnt = 0;
        end else begin
            bit       fl, st;
            logic [2:0] setv;
            fl   = reg_wr && reg_addr == 3'd4 && reg_wdata != 0;
            setv = '0;
            st   = 0;
            if (seq_end) setv[0] = 1'b1;
            if (fl) begin
                q.delete();
                m_cnt = m_thr;
            end else begin
                if (pop && q.size() > 0) void'(q.pop_front());
                if (res_vld) begin
                    if (q.size() < DEPTH) begin
                        q.push_back({res_chan, res_data});
                        st = 1;
                    end else begin
                        setv[2] = 1'b1;
                        if (m_ign) begin
                            void'(q.pop_front());
                            q.push_back({res_chan, res_data});
                            st = 1;
                        end
                    end
                end
            end
            if (reg_wr && reg_addr == 3'd2) begin
                m_thr = int'(reg_wdata[7:0]);
                m_cnt = m_thr;
            end else if (st && m_cnt != 0) begin
                m_cnt--;
                if (m_cnt == 0) setv[1] = 1'b1;
            end
            if (reg_wr && reg_addr == 3'd1) m_flags = m_flags & ~reg_wdata[2:0];
            m_flags = m_flags | setv;
            if (reg_wr && reg_addr == 3'd0) m_ena = reg_wdata[2:0];
            if (reg_wr && reg_addr == 3'd3) m_ign = reg_wdata[0];
        end
    end

    always @(negedge clk) begin
        if (running && rst_n) begin
            chk(fill == CW'(q.size()), "R2 fill", int'(fill), q.size());
            chk(rd_valid == (q.size() > 0), "R2 rd_valid", int'(rd_valid), int'(q.size() > 0));
            if (q.size() > 0) chk(rd_data == q[0], "R2 head", int'(rd_data), int'(q[0]));
            chk(flags == m_flags, "R9 flags", int'(flags), int'(m_flags));
            chk(irq == |(m_flags & m_ena), "R8 irq", int'(irq), int'(|(m_flags & m_ena)));
        end
    end

    task automatic step(input bit pv, input logic [ENT_W-1:0] d, input bit pp,
                        input bit wv, input logic [2:0] a, input logic [15:0] wd, input bit se);
        @(negedge clk);
        res_vld = pv; {res_chan, res_data} = d; pop = pp;
        reg_wr = wv; reg_addr = a; reg_wdata = wd; seq_end = se;
        @(negedge clk);
        res_vld = 0; pop = 0; reg_wr = 0; seq_end = 0;
    endtask

    task automatic push(input logic [ENT_W-1:0] d); step(1, d, 0, 0, 0, 0, 0); endtask
    task automatic wr(input logic [2:0] a, input logic [15:0] wd); step(0, 0, 0, 1, a, wd, 0); endtask

    function automatic logic [ENT_W-1:0] ent(input int i);
        return {CHAN_W'(i), DATA_W'(100 + 3 * i)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        running = 1;
        chk(fill == 0 && !rd_valid, "R1 empty", int'(fill), 0);
        chk(flags == 0 && !irq, "R1 flags", int'({irq, flags}), 0);

        step(0, 0, 1, 0, 0, 0, 0);
        chk(fill == 0 && !rd_valid, "R11 empty pop", int'(fill), 0);

        wr(3'd0, 16'h4);
        for (int i = 0; i < DEPTH; i++) push(ent(i));
        chk(fill == CW'(DEPTH), "R2 full count", int'(fill), DEPTH);
        chk(flags[2] == 0, "R4 no early overrun", int'(flags), 0);

        push(ent(40));
        chk(fill == CW'(DEPTH), "R3 drop fill", int'(fill), DEPTH);
        chk(rd_data == ent(0), "R3 head kept", int'(rd_data), int'(ent(0)));
        chk(flags[2] == 1, "R4 overrun flag", int'(flags), 4);
        chk(irq == 1, "R8 irq on overrun", int'(irq), 1);

        for (int i = 1; i <= 3; i++) begin
            step(0, 0, 1, 0, 0, 0, 0);
            chk(rd_data == ent(i), "R2 pop order", int'(rd_data), int'(ent(i)));
        end

        wr(3'd1, 16'h4);
        chk(flags == 0 && !irq, "R9 w1c", int'({irq, flags}), 0);

        for (int i = 16; i < 19; i++) push(ent(i));
        step(1, ent(41), 0, 1, 3'd1, 16'h4, 0);
        chk(flags[2] == 1, "R9 set wins", int'(flags), 4);

        wr(3'd1, 16'h7);
        wr(3'd3, 16'h1);
        push(ent(42));
        chk(fill == CW'(DEPTH), "R5 overwrite fill", int'(fill), DEPTH);
        chk(rd_data == ent(4), "R5 head advanced", int'(rd_data), int'(ent(4)));
        chk(flags[2] == 1, "R4 overrun in overwrite mode", int'(flags), 4);

        wr(3'd1, 16'h7);
        step(0, 0, 0, 0, 0, 0, 1);
        chk(flags == 3'b001, "R6 seq end flag", int'(flags), 1);
        chk(irq == 0, "R8 masked flag", int'(irq), 0);

        wr(3'd4, 16'h0);
        chk(fill == CW'(DEPTH), "R10 zero write no flush", int'(fill), DEPTH);
        wr(3'd4, 16'h5);
        chk(fill == 0 && !rd_valid, "R10 flush", int'(fill), 0);

        wr(3'd1, 16'h7);
        wr(3'd2, 16'h3);
        push(ent(50));
        push(ent(51));
        chk(flags[1] == 0, "R7 not yet", int'(flags), 0);
        push(ent(52));
        chk(flags[1] == 1, "R7 threshold reached", int'(flags), 2);
        wr(3'd0, 16'h2);
        chk(irq == 1, "R8 threshold irq", int'(irq), 1);

        repeat (2) @(negedge clk);
        done = 1;
        running = 0;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule